// File: doc/BRIEF.md
# Cursor Pattern Memory Access Port

This block gives a host an 8-bit register-style path into the pattern storage of a hardware cursor. The host picks a register with a 4-bit select code and issues a write or read strobe. One select code is the pattern data register: every access to it touches the byte at an internal address counter, and the counter then steps by one. The counter is shared by reads and writes. Another select code loads the low byte of the counter. A third writes the cursor command byte. That byte picks the cursor size, and in the large size it also carries the top two counter bits.

Two separate pattern buffers sit inside the block. One holds 256 bytes for the small 32x32 cursor and the other holds 1024 bytes for the large 64x64 cursor. The current size decides which buffer an access reaches and how wide the counter is before it wraps. Reads are combinational, so data comes back in the access cycle. The counter step lands on the next clock edge. Drawing the cursor on the display is handled elsewhere.

Top module: `cpat_port`

## Requirements
- R1: After reset the counter (addr_o) is 0 and the small size is selected (large_o = 0).
- R2: A write with select 4'h0 loads counter bits [7:0] from wdata_i and clears bits [9:8], in either size.
- R3: A write with select 4'hB stores wdata_i at the current counter address in the buffer of the current size, and the counter steps by one on the same edge.
- R4: A read with select 4'hB returns the addressed byte of the current size's buffer on rdata_o during that cycle, and the counter steps by one on the closing edge.
- R5: In the small size the counter steps modulo 256 (bits [9:8] stay 0), so 0x0FF is followed by 0x000.
- R6: In the large size the counter steps modulo 1024, so 0x3FF is followed by 0x000.
- R7: A write with select 4'hA sets the size from wdata_i bit 2 (1 = 64x64, 0 = 32x32), shown on large_o from the next cycle.
- R8: A write with select 4'hA and wdata_i bit 2 = 1 loads counter bits [9:8] from wdata_i bits [1:0] and keeps bits [7:0]. The same write with bit 2 = 0 leaves the counter unchanged.
- R9: The two buffers are distinct. A write in one size does not change the byte at the same address in the other size.
- R10: Strobes with any other select code leave the counter unchanged, and rdata_o is 0 whenever no data-register read is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 4 | Register select code |
| wr_i | input | 1 | Write strobe for the selected register |
| rd_i | input | 1 | Read strobe for the selected register |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Pattern byte read from the data register |
| addr_o | output | 10 | Current pattern address counter |
| large_o | output | 1 | 1 when the 64x64 cursor size is selected |

## Verification
The bench builds the block with its default widths: 8-bit data, an 8-bit small address and a 10-bit large address. These sizes make both wrap points reachable with a few accesses. The bench first loads the counter just below 0x100 or 0x400, and in the large case sets the top bits through the command byte. At these sizes the small and large buffers also share low addresses, so the bench can check that one buffer is isolated from the other.

// File: rtl/cpat_pkg.sv
package cpat_pkg;
  localparam int unsigned SEL_W = 4;
  localparam logic [SEL_W-1:0] SEL_INDEX = 4'h0;
  localparam logic [SEL_W-1:0] SEL_CMD3  = 4'hA;
  localparam logic [SEL_W-1:0] SEL_DATA  = 4'hB;
endpackage

// File: rtl/cpat_addr_ctr.sv
module cpat_addr_ctr #(
  parameter int unsigned DW       = 8,
  parameter int unsigned SMALL_AW = 8,
  parameter int unsigned LARGE_AW = 10,
  parameter int unsigned SIZE_BIT = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                idx_ld_i,
  input  logic                cmd_wr_i,
  input  logic                step_i,
  input  logic                large_i,
  input  logic [DW-1:0]       wdata_i,
  output logic [LARGE_AW-1:0] addr_o
);
  localparam int unsigned HI_W = LARGE_AW - SMALL_AW;

  logic [LARGE_AW-1:0] addr_q, addr_d;

  always_comb begin
    addr_d = addr_q;
    if (idx_ld_i) begin
      addr_d = {{HI_W{1'b0}}, wdata_i[SMALL_AW-1:0]};
    end else if (cmd_wr_i && wdata_i[SIZE_BIT]) begin
      // high bits ride along with a large-size command write
      addr_d = {wdata_i[HI_W-1:0], addr_q[SMALL_AW-1:0]};
    end else if (step_i) begin
      if (large_i) addr_d = addr_q + 1'b1;
      else         addr_d = {{HI_W{1'b0}}, addr_q[SMALL_AW-1:0] + 1'b1};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else         addr_q <= addr_d;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/cpat_buf.sv
module cpat_buf #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/cpat_port.sv
module cpat_port
  import cpat_pkg::*;
#(
  parameter int unsigned DW       = 8,
  parameter int unsigned SMALL_AW = 8,
  parameter int unsigned LARGE_AW = 10,
  parameter int unsigned SIZE_BIT = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [DW-1:0]       wdata_i,
  output logic [DW-1:0]       rdata_o,
  output logic [LARGE_AW-1:0] addr_o,
  output logic                large_o
);
  logic idx_ld, cmd_wr, data_acc, data_rd, large_q;
  logic [LARGE_AW-1:0] addr;
  logic [DW-1:0] buf_rd [2];

  assign idx_ld   = wr_i && (sel_i == SEL_INDEX);
  assign cmd_wr   = wr_i && (sel_i == SEL_CMD3);
  assign data_acc = (wr_i || rd_i) && (sel_i == SEL_DATA);
  assign data_rd  = rd_i && (sel_i == SEL_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     large_q <= 1'b0;
    else if (cmd_wr) large_q <= wdata_i[SIZE_BIT];
  end

  cpat_addr_ctr #(
    .DW(DW), .SMALL_AW(SMALL_AW), .LARGE_AW(LARGE_AW), .SIZE_BIT(SIZE_BIT)
  ) ctr_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .idx_ld_i (idx_ld),
    .cmd_wr_i (cmd_wr),
    .step_i   (data_acc),
    .large_i  (large_q),
    .wdata_i  (wdata_i),
    .addr_o   (addr)
  );

  // index 0: small buffer, index 1: large buffer
  for (genvar gi = 0; gi < 2; gi++) begin : g_buf
    localparam int unsigned AW = (gi == 0) ? SMALL_AW : LARGE_AW;
    logic sel_this;
    assign sel_this = (gi == 0) ? !large_q : large_q;
    cpat_buf #(.DW(DW), .AW(AW)) buf_i (
      .clk_i   (clk_i),
      .we_i    (wr_i && (sel_i == SEL_DATA) && sel_this),
      .addr_i  (addr[AW-1:0]),
      .wdata_i (wdata_i),
      .rdata_o (buf_rd[gi])
    );
  end

  assign rdata_o = data_rd ? buf_rd[large_q] : '0;
  assign addr_o  = addr;
  assign large_o = large_q;
endmodule

// File: rtl/cpat_port_chk.sv
module cpat_port_chk
  import cpat_pkg::*;
#(
  parameter int unsigned DW       = 8,
  parameter int unsigned SMALL_AW = 8,
  parameter int unsigned LARGE_AW = 10,
  parameter int unsigned SIZE_BIT = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [SEL_W-1:0]    sel_i,
  input logic                wr_i,
  input logic                rd_i,
  input logic [DW-1:0]       wdata_i,
  input logic [DW-1:0]       rdata_o,
  input logic [LARGE_AW-1:0] addr_o,
  input logic                large_o
);
  localparam int unsigned HI_W = LARGE_AW - SMALL_AW;

  // R2
  index_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == SEL_INDEX) |=>
      addr_o == {{HI_W{1'b0}}, $past(wdata_i[SMALL_AW-1:0])});

  // R5
  small_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_i || rd_i) && sel_i == SEL_DATA && !large_o) |=>
      (addr_o[SMALL_AW-1:0] == SMALL_AW'($past(addr_o[SMALL_AW-1:0]) + 1'b1)) &&
      (addr_o[LARGE_AW-1:SMALL_AW] == '0));

  // R6
  large_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_i || rd_i) && sel_i == SEL_DATA && large_o) |=>
      addr_o == LARGE_AW'($past(addr_o) + 1'b1));

  // R7
  size_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == SEL_CMD3) |=> large_o == $past(wdata_i[SIZE_BIT]));

  // R8
  hi_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == SEL_CMD3 && wdata_i[SIZE_BIT]) |=>
      (addr_o[LARGE_AW-1:SMALL_AW] == $past(wdata_i[HI_W-1:0])) &&
      (addr_o[SMALL_AW-1:0] == $past(addr_o[SMALL_AW-1:0])));

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((wr_i || rd_i) && (sel_i == SEL_DATA || sel_i == SEL_INDEX || sel_i == SEL_CMD3))
      |=> $stable(addr_o));

  // R10
  rdata_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && sel_i == SEL_DATA) |-> rdata_o == '0);
endmodule

bind cpat_port cpat_port_chk #(
  .DW(DW), .SMALL_AW(SMALL_AW), .LARGE_AW(LARGE_AW), .SIZE_BIT(SIZE_BIT)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .wr_i(wr_i), .rd_i(rd_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .addr_o(addr_o), .large_o(large_o)
);

// File: tb/cpat_port_tb_top.sv
module cpat_port_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b1;
  logic [3:0] sel_i = 4'h5;
  logic       wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [9:0] addr_o;
  logic       large_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [7:0] s_ref [256];
  logic [7:0] l_ref [1024];
  logic [9:0] m_addr = '0;
  logic       m_large = 1'b0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #5 clk_i = ~clk_i;

  cpat_port dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .wr_i(wr_i), .rd_i(rd_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .addr_o(addr_o), .large_o(large_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic acc(input logic [3:0] s, input logic w, input logic r, input logic [7:0] d);
    @(posedge clk_i); #1;
    sel_i = s; wr_i = w; rd_i = r; wdata_i = d;
    @(posedge clk_i); #1;
    wr_i = 1'b0; rd_i = 1'b0; sel_i = 4'h5;
  endtask

  function automatic logic [9:0] stepped(input logic [9:0] a);
    return m_large ? 10'(a + 1'b1) : {2'b00, 8'(a[7:0] + 1'b1)};
  endfunction

  task automatic set_idx(input logic [7:0] d);
    m_addr = {2'b00, d};
    acc(4'h0, 1'b1, 1'b0, d);
  endtask

  task automatic set_cmd(input logic [7:0] d);
    m_large = d[2];
    if (d[2]) m_addr[9:8] = d[1:0];
    acc(4'hA, 1'b1, 1'b0, d);
  endtask

  task automatic pat_wr(input logic [7:0] d);
    if (m_large) l_ref[m_addr] = d;
    else         s_ref[m_addr[7:0]] = d;
    m_addr = stepped(m_addr);
    acc(4'hB, 1'b1, 1'b0, d);
  endtask

  task automatic pat_rd(input string req);
    exp_q.push_back(m_large ? l_ref[m_addr] : s_ref[m_addr[7:0]]);
    tag_q.push_back(req);
    m_addr = stepped(m_addr);
    acc(4'hB, 1'b0, 1'b1, 8'h00);
  endtask

  task automatic chk_addr(input string req);
    check(addr_o == m_addr, req, addr_o, m_addr);
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && rd_i && sel_i == 4'hB) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 unexpected read", rdata_o, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rdata_o === e, t, rdata_o, e);
      end
    end
  end

  initial begin
    #2 rst_ni = 1'b0;
    #20;
    @(negedge clk_i);
    // R1
    check(addr_o == 10'h0, "R1 addr", addr_o, 0);
    check(large_o == 1'b0, "R1 size", large_o, 0);
    rst_ni = 1'b1;

    set_idx(8'h10);
    chk_addr("R2 index load");
    for (int i = 0; i < 4; i++) pat_wr(8'hC0 + 8'(i));
    chk_addr("R3 write step");
    set_idx(8'h10);
    for (int i = 0; i < 4; i++) pat_rd("R4 small read");
    chk_addr("R4 read step");

    set_idx(8'hFE);
    for (int i = 0; i < 3; i++) pat_wr(8'h50 + 8'(i));
    chk_addr("R5 small wrap");
    set_idx(8'hFE);
    for (int i = 0; i < 3; i++) pat_rd("R5 wrap read");

    set_cmd(8'h07);
    check(large_o == 1'b1, "R7 large select", large_o, 1);
    chk_addr("R8 high load");
    pat_wr(8'h9D);
    chk_addr("R6 large step");
    set_idx(8'h10);
    chk_addr("R2 clears high bits");
    pat_wr(8'hAA);
    set_cmd(8'h03);
    check(large_o == 1'b0, "R7 small select", large_o, 0);
    chk_addr("R8 no high load in small");
    set_idx(8'h10);
    pat_rd("R9 small buffer kept");
    set_cmd(8'h04);
    set_idx(8'h10);
    pat_rd("R9 large buffer read");

    set_idx(8'hFF);
    set_cmd(8'h07);
    pat_wr(8'h3C);
    chk_addr("R6 large wrap");
    set_idx(8'hFF);
    set_cmd(8'h07);
    pat_rd("R6 top byte read");
    chk_addr("R6 wrap after read");

    // R10: foreign selects
    @(posedge clk_i); #1;
    sel_i = 4'h5; wr_i = 1'b1; rd_i = 1'b1; wdata_i = 8'h33;
    @(negedge clk_i);
    check(rdata_o == 8'h00, "R10 rdata idle", rdata_o, 0);
    @(posedge clk_i); #1;
    sel_i = 4'h9; wr_i = 1'b0; rd_i = 1'b1;
    @(posedge clk_i); #1;
    wr_i = 1'b0; rd_i = 1'b0; sel_i = 4'h5;
    chk_addr("R10 counter held");

    repeat (2) @(posedge clk_i);
    check(exp_q.size() == 0, "R4 reads drained", exp_q.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      check(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule